// File: doc/BRIEF.md
# Quad DAC Serial Command Interface

This block is the digital front end of a four-channel, 8-bit converter. A host sends 12-bit command words over a three-wire serial link: a serial clock, a data line and an active-low chip select. The block samples all three pins with a system clock that runs at least four times faster than the serial clock. Data bits are captured on rising serial clock edges while the chip select is low, in SPI mode 0. When the chip select rises, the most recent 12 bits received are decoded as one command. The first two bits are the channel address. The next two bits are the operation code. The last eight bits are the data byte.

The channel data is double-buffered. Each channel has an input (staging) register and a DAC register, and the four DAC registers drive the output bus. Commands can do the following:
- preload a staging register;
- load a staging register and its DAC register together;
- broadcast a byte to every DAC register;
- do nothing;
- transfer every staging register into its DAC register, optionally changing the serial output phase at the same time.

Two more pins act on all channels. An active-low load pin transfers the staging registers into the DAC registers. An active-low clear pin zeroes every staging and DAC register. A serial output carries each bit as it leaves the shift register, so several devices can be chained. The output can change on either the rising or the falling serial clock edge.

A small state machine tracks the framing. In `ST_IDLE` the chip select is high. When the chip select is seen low, the machine moves to `ST_SHIFT`, where it shifts data in and drives the serial output. When the chip select is seen high again, the machine moves to `ST_EXEC` for one cycle, in which the command is applied. It then returns to `ST_IDLE`.

Top module: `quad_dac_cmd_if`

## Requirements
- R1: A command word is 12 bits, sent first bit first: address A1, address A0, operation bit C1, operation bit C0, then data bits D7 down to D0. Bits are captured on rising serial clock edges while the chip select is low. The command executes when the chip select rises, using the last 12 bits received, even when more than 12 bits were sent.
- R2: Operation C1C0=01 writes the data byte into the staging register of channel A1A0 (channel 0 is data bits [7:0] of the output bus, channel 3 is bits [31:24]). No DAC register changes.
- R3: Operation C1C0=11 writes the data byte into both the staging register and the DAC register of channel A1A0.
- R4: Operation C1C0=00 with A0=0 writes the data byte into all four DAC registers, whatever the value of A1. The staging registers are unchanged.
- R5: Operation C1C0=00 with A0=1 changes no staging or DAC register.
- R6: Operation C1C0=10 with A1=0 copies every staging register into its own DAC register.
- R7: Operation C1C0=10 with A1=1 performs the copy of R6. It also sets the output phase: A0=1 selects rising-edge mode and A0=0 selects falling-edge mode.
- R8: The serial output presents the bit that leaves the top stage of the 12-bit shift register. A word sent ahead of 12 further bits therefore reappears at the output in its original order. In rising-edge mode the output changes after the rising serial clock edge. In falling-edge mode it changes only after the following falling edge.
- R9: After reset, all staging and DAC registers are zero, the serial output is 0 and rising-edge mode is selected.
- R10: While the load pin is low, every DAC register takes the value of its staging register.
- R11: While the clear pin is low, every staging and DAC register is zero. Clear overrides the load pin and any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low chip select; command executes when it rises |
| din_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low transfer of staging registers into DAC registers |
| clear_n_i | input | 1 | Active-low clear of all staging and DAC registers |
| dout_o | output | 1 | Serial data out for readback or chaining |
| dac_codes_o | output | 32 | Four DAC register values, channel 0 in the low byte |

## Verification
Several corner cases are targeted directly.
- A 24-bit frame checks that only the trailing word executes. A design that used the first 12 bits would write the wrong channel.
- After a broadcast, a transfer command checks that the staging registers survived. A design that also overwrote them would lose the earlier preloads.
- The serial output is sampled both just before and just after the falling serial clock edge. In falling-edge mode the value must still be the previous bit before that edge, which exposes a design that ignores the phase setting.
- The clear pin is followed by a transfer command. A clear that zeroed only the DAC registers would let the old staging values reappear.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EXEC  = 2'd2
    } fsm_e;

    typedef enum logic [1:0] {
        OP_BCAST_NOP = 2'b00,
        OP_PRELOAD   = 2'b01,
        OP_XFER      = 2'b10,
        OP_DIRECT    = 2'b11
    } op_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int         W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST;
            sync_q <= RST;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
    parameter int WORD = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            fall_en,
    input  logic            bit_in,
    input  logic            mode_rise,
    output logic [WORD-1:0] word_o,
    output logic            dout_o
);
    logic [WORD-1:0] sr_q;
    logic            out_bit_q;
    logic            fall_out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q       <= '0;
            out_bit_q  <= 1'b0;
            fall_out_q <= 1'b0;
        end else begin
            if (shift_en) begin
                sr_q      <= {sr_q[WORD-2:0], bit_in};
                out_bit_q <= sr_q[WORD-1];
            end
            if (fall_en) begin
                fall_out_q <= out_bit_q;
            end
        end
    end

    assign word_o = sr_q;
    assign dout_o = mode_rise ? out_bit_q : fall_out_q;
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [3:0]        cmd,
    input  logic [DW-1:0]     data,
    input  logic              clr_n,
    input  logic              ld_n,
    output logic [NCH*DW-1:0] dac_o,
    output logic              mode_rise
);
    logic [NCH-1:0][DW-1:0] in_q;
    logic [NCH-1:0][DW-1:0] dac_q;
    logic                   mode_q;
    logic [1:0]             sel;
    op_e                    op;

    assign sel = cmd[3:2];
    assign op  = op_e'(cmd[1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= '0;
            dac_q  <= '0;
            mode_q <= 1'b1;
        end else if (!clr_n) begin
            in_q  <= '0;
            dac_q <= '0;
        end else if (!ld_n) begin
            dac_q <= in_q;
        end else if (exec) begin
            unique case (op)
                OP_PRELOAD: in_q[sel] <= data;
                OP_DIRECT: begin
                    in_q[sel]  <= data;
                    dac_q[sel] <= data;
                end
                OP_BCAST_NOP: begin
                    if (!cmd[2]) begin
                        for (int i = 0; i < NCH; i++) dac_q[i] <= data;
                    end
                end
                OP_XFER: begin
                    dac_q <= in_q;
                    if (cmd[3]) mode_q <= cmd[2];
                end
                default: ;
            endcase
        end
    end

    assign dac_o     = dac_q;
    assign mode_rise = mode_q;
endmodule

// File: rtl/quad_dac_cmd_if.sv
module quad_dac_cmd_if
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              din_i,
    input  logic              load_n_i,
    input  logic              clear_n_i,
    output logic              dout_o,
    output logic [NCH*DW-1:0] dac_codes_o
);
    localparam int WORD = DW + 4;

    logic [4:0]      syn;
    logic            s_sclk, s_cs_n, s_din, s_ld_n, s_clr_n;
    logic            prev_sclk_q;
    logic            sclk_rise, sclk_fall;
    logic            shift_en, fall_en, exec_p;
    logic            mode_rise;
    logic [WORD-1:0] word_q;
    fsm_e            state_q, state_d;

    qdac_sync #(.W(5), .RST(5'b11010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clear_n_i, load_n_i, din_i, cs_n_i, sclk_i}),
        .q     (syn)
    );

    assign s_sclk  = syn[0];
    assign s_cs_n  = syn[1];
    assign s_din   = syn[2];
    assign s_ld_n  = syn[3];
    assign s_clr_n = syn[4];

    always_ff @(posedge clk) begin
        if (!rst_n) prev_sclk_q <= 1'b0;
        else        prev_sclk_q <= s_sclk;
    end

    assign sclk_rise = s_sclk & ~prev_sclk_q;
    assign sclk_fall = ~s_sclk & prev_sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!s_cs_n) state_d = ST_SHIFT;
            ST_SHIFT: if (s_cs_n)  state_d = ST_EXEC;
            ST_EXEC:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        fall_en  = 1'b0;
        exec_p   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHIFT: begin
                shift_en = sclk_rise & ~s_cs_n;
                fall_en  = sclk_fall & ~s_cs_n;
            end
            ST_EXEC:  exec_p = 1'b1;
            default: ;
        endcase
    end

    qdac_shifter #(.WORD(WORD)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .fall_en   (fall_en),
        .bit_in    (s_din),
        .mode_rise (mode_rise),
        .word_o    (word_q),
        .dout_o    (dout_o)
    );

    qdac_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec      (exec_p),
        .cmd       (word_q[WORD-1:WORD-4]),
        .data      (word_q[DW-1:0]),
        .clr_n     (s_clr_n),
        .ld_n      (s_ld_n),
        .dac_o     (dac_codes_o),
        .mode_rise (mode_rise)
    );
endmodule

// File: rtl/quad_dac_cmd_if_chk.sv
module quad_dac_cmd_if_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec,
    input logic [3:0]        cmd,
    input logic [DW-1:0]     data,
    input logic              clr_n,
    input logic              ld_n,
    input logic [NCH*DW-1:0] dac
);
    logic quiet;
    assign quiet = clr_n & ld_n;

    AST_PRELOAD_HOLDS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && quiet && cmd[1:0] == 2'b01) |=> $stable(dac)); // R2

    AST_DIRECT_WRITES_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && quiet && cmd[1:0] == 2'b11) |=>
        (DW'(dac >> (DW * $past(cmd[3:2]))) == $past(data))); // R3

    AST_BROADCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && quiet && cmd[1:0] == 2'b00 && !cmd[2]) |=> (dac == {NCH{$past(data)}})); // R4

    AST_NOP_HOLDS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && quiet && cmd[1:0] == 2'b00 && cmd[2]) |=> $stable(dac)); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (dac == '0)); // R11
endmodule

bind quad_dac_cmd_if quad_dac_cmd_if_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .exec  (exec_p),
    .cmd   (word_q[WORD-1:WORD-4]),
    .data  (word_q[DW-1:0]),
    .clr_n (s_clr_n),
    .ld_n  (s_ld_n),
    .dac   (dac_codes_o)
);

// File: tb/quad_dac_cmd_if_tb.sv
module quad_dac_cmd_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, din = 1'b0, load_n = 1'b1, clear_n = 1'b1;
    logic        dout;
    logic [31:0] dac;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;
    logic        hi_s [0:23];
    logic        lo_s [0:23];

    localparam int HALF = 6;

    always #10 clk = ~clk;

    quad_dac_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
        .load_n_i(load_n), .clear_n_i(clear_n), .dout_o(dout), .dac_codes_o(dac)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] bits, input int n);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) begin
            din = bits[n-1-k];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            hi_s[k] = dout;
            sclk = 1'b0;
            wait_clk(HALF);
            lo_s[k] = dout;
        end
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic send_word(input logic [11:0] w);
        send({12'h000, w}, 12);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R9 dac after reset", dac, 32'h0);
        chk("R9 dout after reset", {31'b0, dout}, 32'h0);
    endtask

    task automatic t_preload;
        send_word(12'h111);
        send_word(12'h933);
        chk("R2 preload leaves dac", dac, 32'h0);
    endtask

    task automatic t_xfer;
        send_word(12'h200);
        chk("R6 transfer copies staging", dac, 32'h0033_0011);
    endtask

    task automatic t_direct;
        send_word(12'h7C4);
        chk("R3 direct load dac", dac, 32'h0033_C411);
        send_word(12'h200);
        chk("R3 direct load staging", dac, 32'h0033_C411);
    endtask

    task automatic t_broadcast;
        send_word(12'h05E);
        chk("R4 broadcast A1=0", dac, 32'h5E5E_5E5E);
        send_word(12'h200);
        chk("R4 staging kept", dac, 32'h0033_C411);
        send_word(12'h800);
        chk("R4 broadcast A1=1 zero", dac, 32'h0);
        send_word(12'h200);
        chk("R4 staging kept again", dac, 32'h0033_C411);
    endtask

    task automatic t_nop;
        send_word(12'h4AA);
        send_word(12'hCAA);
        chk("R5 nop leaves dac", dac, 32'h0033_C411);
        send_word(12'h200);
        chk("R5 nop leaves staging", dac, 32'h0033_C411);
    endtask

    task automatic t_load_pin;
        send_word(12'hD77);
        chk("R2 preload ch3", dac, 32'h0033_C411);
        load_n = 1'b0;
        wait_clk(4);
        load_n = 1'b1;
        wait_clk(6);
        chk("R10 load pin", dac, 32'h7733_C411);
    endtask

    task automatic t_daisy_rise;
        logic [11:0] got;
        send({12'h4C3, 12'hF5A}, 24);
        chk("R1 trailing word executes", dac, 32'h5A33_C411);
        for (int i = 0; i < 12; i++) got[11-i] = hi_s[12+i];
        chk("R8 rising mode passes word", {20'b0, got}, 32'h4C3);
    endtask

    task automatic t_mode_fall;
        logic [11:0] got_lo;
        logic [10:0] got_hi;
        send_word(12'hA00);
        chk("R7 mode0 command transfers", dac, 32'h5A33_C411);
        send({12'hC96, 12'h400}, 24);
        for (int i = 0; i < 12; i++) got_lo[11-i] = lo_s[12+i];
        for (int i = 0; i < 11; i++) got_hi[10-i] = hi_s[13+i];
        chk("R8 falling mode after fall", {20'b0, got_lo}, 32'hC96);
        chk("R8 falling mode before fall", {21'b0, got_hi}, {21'b0, 11'h64B});
        send_word(12'hE00);
        send({12'h5A5, 12'hC00}, 24);
        for (int i = 0; i < 12; i++) got_lo[11-i] = hi_s[12+i];
        chk("R7 rising mode restored", {20'b0, got_lo}, 32'h5A5);
        chk("R5 chained nop keeps dac", dac, 32'h5A33_C411);
    endtask

    task automatic t_clear;
        clear_n = 1'b0;
        load_n  = 1'b0;
        wait_clk(4);
        clear_n = 1'b1;
        load_n  = 1'b1;
        wait_clk(6);
        chk("R11 clear zeroes dac", dac, 32'h0);
        send_word(12'h200);
        chk("R11 clear zeroes staging", dac, 32'h0);
    endtask

    initial begin
        t_reset();
        t_preload();
        t_xfer();
        t_direct();
        t_broadcast();
        t_nop();
        t_load_pin();
        t_daisy_rise();
        t_mode_fall();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule